// File: doc/BRIEF.md
# Three-Operand Integer Adder

This block adds three integer operands in one pass. Each operand can first be cut down to one of its 16-bit halves, and each can then be negated in two's complement on its own. The first two operands are added together. That partial sum can be shifted by half the word width to the left or to the right. The third operand is then added to give the result. All arithmetic wraps modulo 2^DATA_W, and no carry leaves the block.

A "plain form" input exists for operand sources that carry no half selects or shift mode, such as immediates or constant operands. When it is set, every operand is taken at full width and the shift is skipped. If a half-select code is illegal, the operand is treated as full width and the block raises a one-cycle error flag together with that result. With the default parameters the result is registered. It appears one cycle after the input is marked valid and holds its value until the next valid input.

Top module: `t3add_top`

## Requirements
- R1: Half-select code 0 passes the whole operand unchanged into the sum.
- R2: Half-select code 1 uses bits 15:0 of the operand, with zeros above them.
- R3: Half-select code 2 uses bits 31:16 of the operand, moved down to bits 15:0, with zeros above them.
- R4: The neg_a, neg_b and neg_c bits each negate their own operand in two's complement, and the negation is applied after half selection.
- R5: Shift-mode code 0 leaves the sum A+B as it is. Code 1 shifts it left by 16. Code 2 shifts it right by 16 logically. Code 3 behaves like code 0.
- R6: Operand C is added after the shift stage, and every addition wraps modulo 2^32.
- R7: When plain_form is 1, all half selects act as code 0 and the shift mode acts as code 0.
- R8: Half-select code 3 is treated as code 0. part_err is 1 in the cycle whose result came from an input with code 3 on any operand, and 0 in the next cycle unless that input also had a code 3.
- R9: part_err stays 0 when plain_form was 1 for the input, whatever the select codes are.
- R10: With REG_OUT=1, out_valid is 1 exactly one cycle after in_valid was 1, and 0 after a cycle in which in_valid was 0.
- R11: During reset and after it, out_valid, result and part_err are 0 until the first valid input.
- R12: result keeps its value while in_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| opa | input | DATA_W | Operand A |
| opb | input | DATA_W | Operand B |
| opc | input | DATA_W | Operand C |
| part_a | input | 2 | Half-select code for A |
| part_b | input | 2 | Half-select code for B |
| part_c | input | 2 | Half-select code for C |
| neg_a | input | 1 | Negate A after selection |
| neg_b | input | 1 | Negate B after selection |
| neg_c | input | 1 | Negate C after selection |
| shift_mode | input | 2 | Shift applied to A+B before C is added |
| plain_form | input | 1 | Force full-width operands and no shift |
| out_valid | output | 1 | Result is valid |
| result | output | DATA_W | Sum |
| part_err | output | 1 | Illegal half-select pulse |

## Verification
The bench uses the default values DATA_W=32 and REG_OUT=1. At 32 bits the 16-bit halves, the shift by 16 and the wrap at 2^32 are exactly the widths that the requirement values describe. With REG_OUT=1 the one-cycle latency, the result hold while in_valid is low, and the single-cycle error pulse can all be observed at the ports.

// File: rtl/t3add_pkg.sv
package t3add_pkg;

  typedef enum logic [1:0] {
    PART_FULL = 2'd0,
    PART_LO   = 2'd1,
    PART_HI   = 2'd2,
    PART_BAD  = 2'd3
  } part_sel_e;

  typedef enum logic [1:0] {
    SHF_NONE  = 2'd0,
    SHF_LEFT  = 2'd1,
    SHF_RIGHT = 2'd2,
    SHF_RSVD  = 2'd3
  } shf_mode_e;

  localparam int unsigned NUM_OPS = 3;

endpackage

// File: rtl/t3add_opcond.sv
module t3add_opcond
  import t3add_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] src,
  input  part_sel_e    part,
  input  logic         neg,
  output logic [W-1:0] dst,
  output logic         bad
);

  localparam int unsigned HW = W / 2;
  localparam int unsigned UW = W - HW;

  logic [W-1:0] narrowed;

  always_comb begin
    bad      = 1'b0;
    narrowed = src;
    case (part)
      PART_FULL: narrowed = src;
      PART_LO:   narrowed = {{UW{1'b0}}, src[HW-1:0]};
      PART_HI:   narrowed = {{HW{1'b0}}, src[W-1:HW]};
      default: begin
        narrowed = src;
        bad      = 1'b1;
      end
    endcase
  end

  always_comb begin
    if (neg) dst = (~narrowed) + {{(W-1){1'b0}}, 1'b1};
    else     dst = narrowed;
  end

  // R2
  lo_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (part == PART_LO && !neg) |-> (dst[W-1:HW] == '0));

  // R3
  hi_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (part == PART_HI && !neg) |-> (dst[W-1:UW] == '0));

  // R4
  neg_sum_chk: assert property (@(posedge clk) disable iff (rst)
    neg |-> ((dst + narrowed) == '0));

endmodule

// File: rtl/t3add_sum.sv
module t3add_sum
  import t3add_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] ca,
  input  logic [W-1:0] cb,
  input  logic [W-1:0] cc,
  input  shf_mode_e    mode,
  output logic [W-1:0] sum
);

  localparam int unsigned SH = W / 2;

  logic [W-1:0] pair;
  logic [W-1:0] shifted;
  logic [W-1:0] pre_c;

  assign pair = ca + cb;

  always_comb begin
    case (mode)
      SHF_LEFT:  shifted = pair << SH;
      SHF_RIGHT: shifted = pair >> SH;
      default:   shifted = pair;
    endcase
  end

  assign sum   = shifted + cc;
  assign pre_c = sum - cc;

  // R5
  left_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == SHF_LEFT) |-> (pre_c[SH-1:0] == '0));

  // R5
  right_high_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == SHF_RIGHT) |-> (pre_c[W-1:W-SH] == '0));

endmodule

// File: rtl/t3add_top.sv
module t3add_top
  import t3add_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] opc,
  input  logic [1:0]        part_a,
  input  logic [1:0]        part_b,
  input  logic [1:0]        part_c,
  input  logic              neg_a,
  input  logic              neg_b,
  input  logic              neg_c,
  input  logic [1:0]        shift_mode,
  input  logic              plain_form,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              part_err
);

  logic [DATA_W-1:0] op_raw  [NUM_OPS];
  logic [1:0]        sel_raw [NUM_OPS];
  logic              neg_raw [NUM_OPS];
  part_sel_e         sel_eff [NUM_OPS];
  logic [DATA_W-1:0] op_cond [NUM_OPS];
  logic [NUM_OPS-1:0] op_bad;

  assign op_raw[0]  = opa;
  assign op_raw[1]  = opb;
  assign op_raw[2]  = opc;
  assign sel_raw[0] = part_a;
  assign sel_raw[1] = part_b;
  assign sel_raw[2] = part_c;
  assign neg_raw[0] = neg_a;
  assign neg_raw[1] = neg_b;
  assign neg_raw[2] = neg_c;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    assign sel_eff[g] = plain_form ? PART_FULL : part_sel_e'(sel_raw[g]);

    t3add_opcond #(.W(DATA_W)) i_cond (
      .clk  (clk),
      .rst  (rst),
      .src  (op_raw[g]),
      .part (sel_eff[g]),
      .neg  (neg_raw[g]),
      .dst  (op_cond[g]),
      .bad  (op_bad[g])
    );
  end

  shf_mode_e         mode_eff;
  logic [DATA_W-1:0] sum_now;
  logic              err_now;

  assign mode_eff = plain_form ? SHF_NONE : shf_mode_e'(shift_mode);
  assign err_now  = in_valid & (|op_bad);

  t3add_sum #(.W(DATA_W)) i_sum (
    .clk  (clk),
    .rst  (rst),
    .ca   (op_cond[0]),
    .cb   (op_cond[1]),
    .cc   (op_cond[2]),
    .mode (mode_eff),
    .sum  (sum_now)
  );

  if (REG_OUT) begin : g_reg
    logic              vld_q;
    logic [DATA_W-1:0] res_q;
    logic              err_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        vld_q <= 1'b0;
        res_q <= '0;
        err_q <= 1'b0;
      end else begin
        vld_q <= in_valid;
        err_q <= err_now;
        if (in_valid) res_q <= sum_now;
      end
    end

    assign out_valid = vld_q;
    assign result    = res_q;
    assign part_err  = err_q;

    // R10
    valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

    // R12
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(result));

    // R8
    err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
      part_err |-> out_valid);

    // R9
    plain_no_err_chk: assert property (@(posedge clk) disable iff (rst)
      (in_valid && plain_form) |=> !part_err);
  end else begin : g_comb
    assign out_valid = in_valid;
    assign result    = sum_now;
    assign part_err  = err_now;

    // R8
    err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
      part_err |-> out_valid);
  end

endmodule

// File: tb/test_t3add_top.sv
`timescale 1ns/1ps
module test_t3add_top;

  localparam int unsigned DW = 32;
  localparam int unsigned NV = 12;

  logic          clk = 1'b0;
  logic          rst;
  logic          in_valid;
  logic [DW-1:0] opa, opb, opc;
  logic [1:0]    part_a, part_b, part_c;
  logic          neg_a, neg_b, neg_c;
  logic [1:0]    shift_mode;
  logic          plain_form;
  logic          out_valid;
  logic [DW-1:0] result;
  logic          part_err;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  t3add_top #(.DATA_W(DW), .REG_OUT(1'b1)) i_t3add_top (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .opa(opa), .opb(opb), .opc(opc),
    .part_a(part_a), .part_b(part_b), .part_c(part_c),
    .neg_a(neg_a), .neg_b(neg_b), .neg_c(neg_c),
    .shift_mode(shift_mode), .plain_form(plain_form),
    .out_valid(out_valid), .result(result), .part_err(part_err)
  );

  // ctl = {plain, shift[1:0], neg_a, neg_b, neg_c, part_a, part_b, part_c}
  localparam logic [31:0] T_A [NV] = '{
    32'h00000001, 32'h12345678, 32'h00000005, 32'hFFFF0001,
    32'h00001234, 32'hFFFF0000, 32'h00000100, 32'hFFFFFFFF,
    32'h12345678, 32'h00030000, 32'h00030000, 32'h0000000A};
  localparam logic [31:0] T_B [NV] = '{
    32'h00000002, 32'hABCD0000, 32'h00000003, 32'h00000000,
    32'h00000001, 32'h00020000, 32'h00000200, 32'h00000001,
    32'h00010000, 32'h00000001, 32'h00000001, 32'h00000000};
  localparam logic [31:0] T_C [NV] = '{
    32'h00000003, 32'h00000000, 32'h00000000, 32'h00000010,
    32'h00000007, 32'h00000010, 32'h00000001, 32'hFFFFFFFF,
    32'h00000001, 32'h00000000, 32'h00000000, 32'h00050000};
  localparam logic [11:0] T_CTL [NV] = '{
    12'b0_00_000_00_00_00, 12'b0_00_000_01_10_00,
    12'b0_00_100_00_00_00, 12'b0_00_100_01_00_00,
    12'b0_01_000_00_00_00, 12'b0_10_000_00_00_00,
    12'b0_11_000_00_00_00, 12'b0_00_000_00_00_00,
    12'b1_01_000_01_10_00, 12'b0_00_000_11_00_00,
    12'b1_00_000_11_00_00, 12'b0_00_001_00_00_10};
  localparam logic [31:0] T_RES [NV] = '{
    32'h00000006, 32'h00010245, 32'hFFFFFFFE, 32'h0000000F,
    32'h12350007, 32'h00000011, 32'h00000301, 32'hFFFFFFFF,
    32'h12355679, 32'h00030001, 32'h00030001, 32'h00000005};
  localparam logic [NV-1:0] T_ERR = 12'b0000_0010_0000_0000;

  function automatic string req_of(input int i);
    case (i)
      0:       return "R1";
      1:       return "R2 R3";
      2, 3:    return "R4";
      4, 5, 6: return "R5";
      7:       return "R6";
      8:       return "R7";
      9:       return "R8";
      10:      return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic drive(input int i);
    opa        = T_A[i];
    opb        = T_B[i];
    opc        = T_C[i];
    plain_form = T_CTL[i][11];
    shift_mode = T_CTL[i][10:9];
    neg_a      = T_CTL[i][8];
    neg_b      = T_CTL[i][7];
    neg_c      = T_CTL[i][6];
    part_a     = T_CTL[i][5:4];
    part_b     = T_CTL[i][3:2];
    part_c     = T_CTL[i][1:0];
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    rst = 1'b1; in_valid = 1'b0; drive(0);
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", {31'b0, out_valid}, 0);
    check("R11", result, 0);
    check("R11", {31'b0, part_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check("R11", result, 0);

    for (int i = 0; i < NV; i++) begin
      drive(i);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(req_of(i), result, T_RES[i]);
      check("R8", {31'b0, part_err}, {31'b0, T_ERR[i]});
      check("R10", {31'b0, out_valid}, 1);
    end

    // R10 latency: nothing before the clock edge, valid after it
    @(negedge clk);
    drive(0);
    in_valid = 1'b1;
    #1;
    check("R10", {31'b0, out_valid}, 0);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", {31'b0, out_valid}, 1);
    check("R1", result, 32'h00000006);

    // R12 hold with changing inputs while idle
    held = result;
    opa = 32'hDEADBEEF; opb = 32'h01020304;
    repeat (2) @(negedge clk);
    check("R12", result, held);
    check("R10", {31'b0, out_valid}, 0);

    // R8 pulse lasts one cycle
    drive(9);
    in_valid = 1'b1;
    @(negedge clk);
    drive(0);
    check("R8", {31'b0, part_err}, 1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R8", {31'b0, part_err}, 0);
    check("R1", result, 32'h00000006);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule